// File: doc/BRIEF.md
# Two-Output Interrupt Controller

This block collects interrupt requests from on-chip peripherals and from four external pins. It holds each request in a raw flag register. Software reads and writes the block through a small memory-mapped register bus. The raw flags are filtered by per-source enable bits. A master enable can silence the processor outputs as a whole. Each source is then routed to one of two processor lines: a normal interrupt (`irq_o`) or a fast interrupt (`fiq_o`).

Peripheral lines are synchronous to the block clock, and a rising edge on one of them latches its flag. External pins pass through a two-flop synchroniser and a per-pin polarity inverter. Each pin can then be sensed by edge or by level. Software acknowledges an edge request by writing a one to the matching bit of a write-only clear register. A test register can force flags to one, so the output path can be exercised without real sources. In normal operation software keeps the test register at zero.

Top module: `intc_two_out`

## Requirements
- R1: After reset every readable register (offsets 0x00, 0x08, 0x0C, 0x10, 0x14, 0x18) reads 0x0000, and both `irq_o` and `fiq_o` are low.
- R2: A rising edge on a peripheral line `src_i[k]` (k in 4..9 or 11..13) sets raw flag k (offset 0x08) at the next clock edge. A line that simply stays high does not set the flag again after it has been cleared.
- R3: Bits 14 and 10 of the enable, select, raw-flag, masked-flag and test registers always read 0, and bit 15 of all of them except the enable register reads 0. `src_i` bits 15, 14, 10 and 3..0 have no effect on the raw flags.
- R4: Writing offset 0x04 clears every edge-mode raw flag whose data bit is 1. A data bit of 0 leaves its flag unchanged. Offset 0x04 reads as 0.
- R5: If a flag is set (edge, level or test force) in the same cycle that software clears it, the flag ends up set.
- R6: The masked view at offset 0x14 equals the raw flags ANDed with enable bits 14..0, whatever the value of master-enable bit 15.
- R7: `irq_o` is high when enable bit 15 is 1 and some masked flag has select bit (offset 0x0C) 0. `fiq_o` is the same for masked flags with select bit 1.
- R8: While enable bit 15 is 0, `irq_o` and `fiq_o` stay low.
- R9: External pin n is configured by bits [2n+1:2n] at offset 0x10. Bit 2n = 0 selects edge sensing, and bit 2n+1 = 1 inverts the pin. In edge mode, an active-going change on the pin sets flag n at the third clock edge after the change (two synchroniser stages, then the flag).
- R10: In level mode (bit 2n = 1) flag n follows the synchronised, polarity-adjusted pin with the same latency. A clear has no effect while the pin is active.
- R11: A 1 in test-register bit k (offset 0x18) forces raw flag k to 1 from the next edge on. While the bit stays set, a clear cannot remove the flag.
- R12: Registers read back what was written, restricted to their implemented bits: enable keeps bits 15, 13..11 and 9..0; select and test keep 13..11 and 9..0; configuration keeps bits 7..0. Offsets that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register, valid in the same cycle |
| src_i | input | 16 | Peripheral request lines at their flag positions; bits 15, 14, 10, 3..0 unused |
| ext_i | input | 4 | Asynchronous external request pins |
| irq_o | output | 1 | Normal interrupt to the processor |
| fiq_o | output | 1 | Fast interrupt to the processor |

## Verification
Some rules are checked by assertions on every cycle. These are: a set beating a simultaneous clear, an edge-mode clear taking effect, a level flag dropping when its line goes inactive, the synchroniser stage shifts, and register write-back. Each output line is also checked against its master enable and its routed masked flags. Other behaviour only the bench's scenarios can show. This covers the exact three-edge latency of an external pin and a polarity flip that creates a request. It also covers peripheral lines that stay high and do not set their flag again. The remaining scenario checks are that unused request bits leave no trace, that a test force survives a clear, and the read-back masks at each offset.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int REG_W = 16;
  localparam int N_EXT = 4;
  localparam int ADDR_W = 5;
  localparam int MASTER_BIT = REG_W - 1;

  // Which flag positions carry a request, and which enable bits exist.
  localparam logic [REG_W-1:0] SRC_MASK = 16'h3BFF;
  localparam logic [REG_W-1:0] EN_MASK  = SRC_MASK | (16'h1 << MASTER_BIT);

  localparam int OFS_EN  = 'h00;
  localparam int OFS_CLR = 'h04;
  localparam int OFS_RAW = 'h08;
  localparam int OFS_SEL = 'h0C;
  localparam int OFS_CFG = 'h10;
  localparam int OFS_MSK = 'h14;
  localparam int OFS_TST = 'h18;

  // Raw flags filtered by the per-source enables; master bit not involved.
  function automatic logic [REG_W-1:0] masked_view(input logic [REG_W-1:0] raw,
                                                   input logic [REG_W-1:0] en);
    return raw & {1'b0, en[MASTER_BIT-1:0]};
  endfunction

  // One processor line: master gate over the sources routed to it.
  function automatic logic line_out(input logic [REG_W-1:0] msk,
                                    input logic [REG_W-1:0] route,
                                    input logic master,
                                    input logic fast);
    logic [REG_W-1:0] pick;
    pick = fast ? route : ~route;
    return master & (|(msk & pick));
  endfunction

endpackage

// File: rtl/intc_ext_sync.sv
module intc_ext_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] inv_i,
  output logic [N-1:0] act_o
);
  logic [N-1:0] stg1_q, stg2_q;
  logic         armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q  <= '0;
      stg2_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      stg1_q  <= pin_i;
      stg2_q  <= stg1_q;
      armed_q <= 1'b1;
    end
  end

  assign act_o = stg2_q ^ inv_i;

  // R9: each synchroniser stage carries the value one edge later
  p_sync_stage1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (stg1_q == $past(pin_i)));
  p_sync_stage2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (stg2_q == $past(stg1_q)));

endmodule

// File: rtl/intc_flags.sv
module intc_flags #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    USED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] lvl_mode_i,
  input  logic [W-1:0] force_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] req_d_q;
  logic [W-1:0] rise_w;
  logic [W-1:0] set_w;
  logic [W-1:0] nxt_w;

  assign rise_w = req_i & ~req_d_q;
  assign set_w  = ((rise_w & ~lvl_mode_i) | (req_i & lvl_mode_i) | force_i) & USED;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (USED[i]) begin : g_live
      always_comb begin
        if (lvl_mode_i[i]) nxt_w[i] = req_i[i] | force_i[i];
        else               nxt_w[i] = set_w[i] | (flag_o[i] & ~clr_i[i]);
      end
    end else begin : g_dead
      assign nxt_w[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d_q <= '0;
      flag_o  <= '0;
    end else begin
      req_d_q <= req_i;
      flag_o  <= nxt_w;
    end
  end

  // R5: a set in the same cycle as a clear leaves the flag set
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w != '0) |=> ((flag_o & $past(set_w)) == $past(set_w)));

  // R4: an edge-mode clear without a competing set empties the flag
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_w & ~lvl_mode_i & USED) != '0)
      |=> ((flag_o & $past(clr_i & ~set_w & ~lvl_mode_i & USED)) == '0));

  // R10: level flags drop once the line and the force are both inactive
  p_level_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_mode_i & ~req_i & ~force_i) != '0)
      |=> ((flag_o & $past(lvl_mode_i & ~req_i & ~force_i)) == '0));

endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int W     = REG_W,
  parameter int AW    = ADDR_W,
  parameter int NE    = N_EXT,
  parameter logic [W-1:0] SMASK = SRC_MASK,
  parameter logic [W-1:0] EMASK = EN_MASK
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel_i,
  input  logic            bus_wr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [W-1:0]    bus_wdata_i,
  output logic [W-1:0]    bus_rdata_o,
  input  logic [W-1:0]    flag_i,
  input  logic [W-1:0]    masked_i,
  output logic [W-1:0]    en_o,
  output logic [W-1:0]    route_o,
  output logic [2*NE-1:0] cfg_o,
  output logic [W-1:0]    test_o,
  output logic [W-1:0]    clr_o
);
  localparam int CFG_W = 2 * NE;

  logic wr_en_w, wr_sel_w, wr_cfg_w, wr_tst_w, wr_clr_w;
  logic wr_w;

  assign wr_w     = bus_sel_i & bus_wr_i;
  assign wr_en_w  = wr_w && (bus_addr_i == AW'(OFS_EN));
  assign wr_clr_w = wr_w && (bus_addr_i == AW'(OFS_CLR));
  assign wr_sel_w = wr_w && (bus_addr_i == AW'(OFS_SEL));
  assign wr_cfg_w = wr_w && (bus_addr_i == AW'(OFS_CFG));
  assign wr_tst_w = wr_w && (bus_addr_i == AW'(OFS_TST));

  assign clr_o = wr_clr_w ? (bus_wdata_i & SMASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o    <= '0;
      route_o <= '0;
      cfg_o   <= '0;
      test_o  <= '0;
    end else begin
      if (wr_en_w)  en_o    <= bus_wdata_i & EMASK;
      if (wr_sel_w) route_o <= bus_wdata_i & SMASK;
      if (wr_cfg_w) cfg_o   <= bus_wdata_i[CFG_W-1:0];
      if (wr_tst_w) test_o  <= bus_wdata_i & SMASK;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_wr_i) begin
      case (bus_addr_i)
        AW'(OFS_EN):  bus_rdata_o = en_o;
        AW'(OFS_RAW): bus_rdata_o = flag_i;
        AW'(OFS_SEL): bus_rdata_o = route_o;
        AW'(OFS_CFG): bus_rdata_o = W'(cfg_o);
        AW'(OFS_MSK): bus_rdata_o = masked_i;
        AW'(OFS_TST): bus_rdata_o = test_o;
        default:      bus_rdata_o = '0;
      endcase
    end
  end

  // R12: a write to the enable register lands with its implemented bits
  p_en_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_w |=> (en_o == $past(bus_wdata_i & EMASK)));
  p_sel_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel_w |=> (route_o == $past(bus_wdata_i & SMASK)));

endmodule

// File: rtl/intc_two_out.sv
module intc_two_out
  import intc_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int AW = ADDR_W,
  parameter int NE = N_EXT,
  parameter logic [W-1:0] SMASK = SRC_MASK,
  parameter logic [W-1:0] EMASK = EN_MASK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel_i,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [W-1:0]  bus_wdata_i,
  output logic [W-1:0]  bus_rdata_o,
  input  logic [W-1:0]  src_i,
  input  logic [NE-1:0] ext_i,
  output logic          irq_o,
  output logic          fiq_o
);
  localparam int CFG_W = 2 * NE;

  logic [W-1:0]     en_w, route_w, test_w, clr_w;
  logic [CFG_W-1:0] cfg_w;
  logic [W-1:0]     flag_w, masked_w;
  logic [W-1:0]     req_w, lvl_mode_w;
  logic [NE-1:0]    ext_inv_w, ext_act_w;
  logic             master_w;

  for (genvar n = 0; n < NE; n++) begin : g_cfg
    assign ext_inv_w[n] = cfg_w[2*n+1];
  end

  for (genvar i = 0; i < W; i++) begin : g_req
    if (i < NE) begin : g_ext
      assign req_w[i]      = ext_act_w[i];
      assign lvl_mode_w[i] = cfg_w[2*i];
    end else begin : g_int
      assign req_w[i]      = src_i[i];
      assign lvl_mode_w[i] = 1'b0;
    end
  end

  intc_ext_sync #(.N(NE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (ext_i),
    .inv_i (ext_inv_w),
    .act_o (ext_act_w)
  );

  intc_flags #(.W(W), .USED(SMASK)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_w),
    .lvl_mode_i (lvl_mode_w),
    .force_i    (test_w),
    .clr_i      (clr_w),
    .flag_o     (flag_w)
  );

  intc_regs #(.W(W), .AW(AW), .NE(NE), .SMASK(SMASK), .EMASK(EMASK)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .flag_i      (flag_w),
    .masked_i    (masked_w),
    .en_o        (en_w),
    .route_o     (route_w),
    .cfg_o       (cfg_w),
    .test_o      (test_w),
    .clr_o       (clr_w)
  );

  assign master_w = en_w[MASTER_BIT];
  assign masked_w = masked_view(flag_w, en_w);
  assign irq_o    = line_out(masked_w, route_w, master_w, 1'b0);
  assign fiq_o    = line_out(masked_w, route_w, master_w, 1'b1);

  // R8: no output while the master enable is off
  p_master_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_w[MASTER_BIT] |-> (!irq_o && !fiq_o));

  // R7: each output is backed by an enabled flag routed to it
  p_irq_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((flag_w & en_w & ~route_w & SMASK) != '0));
  p_fiq_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> ((flag_w & en_w & route_w & SMASK) != '0));

endmodule

// File: tb/intc_two_out_test.sv
module intc_two_out_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [4:0]  bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic [15:0] src_i = '0;
  logic [3:0]  ext_i = '0;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    int          kind;   // 0 read data, 1 irq_o, 2 fiq_o
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  intc_two_out uut (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .src_i(src_i), .ext_i(ext_i), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always #10 clk = ~clk;

  // Monitor: pops queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] got;
      it = sb.pop_front();
      got = (it.kind == 0) ? bus_rdata_o : (it.kind == 1) ? {15'b0, irq_o} : {15'b0, fiq_o};
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk); #2;
    bus_sel_i = 0; bus_wr_i = 0;
  endtask

  task automatic expect_rd(input logic [4:0] a, input logic [15:0] e, input string r);
    @(posedge clk); #2;
    bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = a;
    sb.push_back('{0, e, r});
    @(negedge clk); #1;
    bus_sel_i = 0;
  endtask

  task automatic expect_out(input logic i, input logic f, input string r);
    sb.push_back('{1, {15'b0, i}, r});
    sb.push_back('{2, {15'b0, f}, r});
    @(negedge clk); #1;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1: reset state
    expect_rd(5'h00, 16'h0000, "R1");
    expect_rd(5'h08, 16'h0000, "R1");
    expect_rd(5'h0C, 16'h0000, "R1");
    expect_rd(5'h10, 16'h0000, "R1");
    expect_rd(5'h14, 16'h0000, "R1");
    expect_rd(5'h18, 16'h0000, "R1");
    expect_out(0, 0, "R1");

    // R12 and R3: implemented bits and unmapped offsets
    wr(5'h00, 16'hFFFF); expect_rd(5'h00, 16'hBBFF, "R12_R3");
    wr(5'h0C, 16'hFFFF); expect_rd(5'h0C, 16'h3BFF, "R12_R3");
    wr(5'h10, 16'hFFFF); expect_rd(5'h10, 16'h00FF, "R12");
    expect_rd(5'h04, 16'h0000, "R4");
    expect_rd(5'h1C, 16'h0000, "R12");
    wr(5'h00, 16'h0000); wr(5'h0C, 16'h0000); wr(5'h10, 16'h0000);

    // R11: test force on every used flag
    wr(5'h18, 16'hFFFF);
    expect_rd(5'h18, 16'h3BFF, "R12_R3");
    expect_rd(5'h08, 16'h3BFF, "R11");
    wr(5'h18, 16'h0000);
    wr(5'h04, 16'hFFFF);
    expect_rd(5'h08, 16'h0000, "R4");

    // R2: peripheral edge, R6 masking, R8 master, R7 routing
    @(posedge clk); #2 src_i = 16'h0040;
    expect_rd(5'h08, 16'h0040, "R2");
    expect_rd(5'h14, 16'h0000, "R6");
    wr(5'h00, 16'h0040);
    expect_rd(5'h14, 16'h0040, "R6");
    expect_out(0, 0, "R8");
    wr(5'h00, 16'h8040);
    expect_out(1, 0, "R7");
    wr(5'h0C, 16'h0040);
    expect_out(0, 1, "R7");
    wr(5'h04, 16'h0040);
    expect_rd(5'h08, 16'h0000, "R4");
    expect_rd(5'h08, 16'h0000, "R2");
    expect_out(0, 0, "R7");
    @(posedge clk); #2 src_i = 16'h0140;
    expect_rd(5'h08, 16'h0100, "R2");
    wr(5'h04, 16'h0000);
    expect_rd(5'h08, 16'h0100, "R4");
    @(posedge clk); #2 src_i = 16'h0140 | 16'hC40F;
    expect_rd(5'h08, 16'h0100, "R3");

    // R5: rising edge on bit 7 in the same cycle as a clear of bits 7 and 8
    @(posedge clk); #2;
    bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = 5'h04; bus_wdata_i = 16'h0180;
    src_i = src_i | 16'h0080;
    @(posedge clk); #2;
    bus_sel_i = 0; bus_wr_i = 0;
    expect_rd(5'h08, 16'h0080, "R5");

    // R9: external edge latency and polarity
    wr(5'h04, 16'hFFFF);
    @(posedge clk); #2 ext_i = 4'b0010;
    wait_edges(1);
    expect_rd(5'h08, 16'h0000, "R9");
    expect_rd(5'h08, 16'h0002, "R9");
    wr(5'h10, 16'h0020);
    expect_rd(5'h08, 16'h0006, "R9");
    wr(5'h04, 16'h0004);
    expect_rd(5'h08, 16'h0002, "R9");
    ext_i = 4'b0110;
    wait_edges(3);
    expect_rd(5'h08, 16'h0002, "R9");
    ext_i = 4'b0010;
    wait_edges(3);
    expect_rd(5'h08, 16'h0006, "R9");

    // R10: level mode on line 3
    wr(5'h04, 16'hFFFF);
    expect_rd(5'h08, 16'h0000, "R4");
    wr(5'h10, 16'h0060);
    ext_i = 4'b1010;
    wait_edges(3);
    expect_rd(5'h08, 16'h0008, "R10");
    wr(5'h04, 16'h0008);
    expect_rd(5'h08, 16'h0008, "R10");
    ext_i = 4'b0010;
    wait_edges(3);
    expect_rd(5'h08, 16'h0000, "R10");

    // R11: forced flag drives the fast line and survives a clear
    wr(5'h18, 16'h2000);
    wr(5'h00, 16'hA000);
    wr(5'h0C, 16'h2000);
    expect_out(0, 1, "R11");
    wr(5'h04, 16'h2000);
    expect_rd(5'h08, 16'h2000, "R11");
    wr(5'h18, 16'h0000);
    wr(5'h04, 16'h2000);
    expect_rd(5'h08, 16'h0000, "R11");
    expect_out(0, 0, "R11");

    @(posedge clk); #2;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule